// File: doc/BRIEF.md
# Latch-Based Output Expander Controller

This block turns a handful of pins into a large set of output-only lines. It drives a bank of external edge-triggered latches. A shared data bus goes to the D inputs of every latch, and each latch has its own clock line. Adding one latch adds one clock pin and a whole data-bus width of outputs. For example, two 8-bit latches need 8 data pins plus 2 clock pins, which gives 16 outputs.

A host asks for a change through a valid/ready request port. The request carries an output index and the bit value wanted on that output. The block keeps a shadow copy of the word last committed to each latch. It changes only the addressed bit of the addressed latch's shadow and puts the whole updated word on the data bus. After a programmable setup time it pulses that latch's clock line high for a programmable width. It then holds the data for a programmable time before it takes the next request. Only one update runs at a time, so requests are serialized. An index outside the output range is accepted and dropped.

Top module: `latch_expander`

## Requirements
- R1: After reset the data bus and every clock line are low, every shadow word is zero, and `req_ready_o` is high.
- R2: Output index i maps to latch i / DATA_W and to bit i % DATA_W within that latch. Data bus bit k feeds bit k of every latch, and `strobe_o[n]` clocks latch n. The valid indices run from 0 to N_LATCH*DATA_W-1.
- R3: An accepted in-range request changes only the addressed bit of the target latch's shadow. The data bus then carries the full updated shadow word of that latch.
- R4: The data bus takes the new word on the cycle after acceptance. Every clock line then stays low for exactly SETUP_CYC cycles.
- R5: After setup, only the target latch's clock line goes high, and it stays high for exactly PULSE_CYC cycles. No two clock lines are ever high together.
- R6: The data bus stays unchanged from the cycle after acceptance until HOLD_CYC cycles after the clock line has fallen.
- R7: `req_ready_o` is low from the cycle after an in-range acceptance until the hold time ends. A request held valid during that time is not taken until ready returns.
- R8: A request with index N_LATCH*DATA_W or higher is accepted and ignored. Ready stays high, no clock line pulses, the data bus is unchanged, and no shadow word changes.
- R9: `line_is_out_o` reports every expanded line as an output (all bits 1) at all times.
- R10: An update to one latch leaves every other latch's shadow word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready; high only when idle |
| req_idx_i | input | IDX_W | Output index; IDX_W = clog2(N_LATCH*DATA_W)+1 |
| req_val_i | input | 1 | Value for the addressed output |
| data_o | output | DATA_W | Shared data bus to all latch D inputs |
| strobe_o | output | N_LATCH | Per-latch clock lines |
| line_is_out_o | output | N_LATCH*DATA_W | Direction report, 1 = output |

## Verification
The assertions check the following on every cycle:
- At most one clock line is high at a time.
- The data bus is frozen for the whole setup, pulse and hold sequence.
- Ready drops after an in-range acceptance.
- An out-of-range request leaves the shadows, clock lines and bus untouched.
- An update to one latch leaves the shadows of the other latches unchanged.

Only the bench scenarios can show the rest:
- The mapping from index to latch and bit.
- The read-modify-write result seen as the word on the bus.
- The exact setup, pulse and hold lengths.
- The ordering of back-to-back requests held valid through a busy period.

// File: rtl/lx_pkg.sv
package lx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} seq_state_e;

  function automatic int unsigned cnt_width(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m);
  endfunction
endpackage

// File: rtl/lx_index_decode.sv
module lx_index_decode #(
  parameter int N_LATCH = 2,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 5
) (
  input  logic [IDX_W-1:0]                    idx_i,
  output logic [N_LATCH-1:0][DATA_W-1:0]      hit_o
);
  // one comparator per expanded line: latch = idx / DATA_W, bit = idx % DATA_W
  for (genvar l = 0; l < N_LATCH; l++) begin : g_lat
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign hit_o[l][b] = (idx_i == IDX_W'(l * DATA_W + b));
    end
  end
endmodule

// File: rtl/lx_shadow_bank.sv
module lx_shadow_bank #(
  parameter int N_LATCH = 2,
  parameter int DATA_W  = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                commit_i,
  input  logic                                val_i,
  input  logic [N_LATCH-1:0][DATA_W-1:0]      hit_i,
  output logic [N_LATCH-1:0]                  sel_o,
  output logic [DATA_W-1:0]                   word_o,
  output logic                                in_range_o
);
  logic [N_LATCH-1:0][DATA_W-1:0] shadow_q;
  logic [N_LATCH-1:0][DATA_W-1:0] nxt;

  for (genvar l = 0; l < N_LATCH; l++) begin : g_lat
    assign sel_o[l] = |hit_i[l];
    assign nxt[l]   = val_i ? (shadow_q[l] | hit_i[l]) : (shadow_q[l] & ~hit_i[l]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   shadow_q[l] <= '0;
      else if (commit_i && sel_o[l]) shadow_q[l] <= nxt[l];
    end

    // R10
    other_latch_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && !sel_o[l]) |=> $stable(shadow_q[l]));
  end

  always_comb begin
    word_o = '0;
    for (int l = 0; l < N_LATCH; l++)
      if (sel_o[l]) word_o = word_o | nxt[l];
  end

  assign in_range_o = |sel_o;

  // R2
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  // R8
  oor_shadow_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !in_range_o) |=> $stable(shadow_q));
endmodule

// File: rtl/lx_strobe_seq.sv
module lx_strobe_seq
  import lx_pkg::*;
#(
  parameter int N_LATCH   = 2,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_LATCH-1:0] sel_i,
  input  logic [DATA_W-1:0]  word_i,
  output logic [DATA_W-1:0]  data_o,
  output logic [N_LATCH-1:0] strobe_o,
  output logic               idle_o
);
  localparam int CNT_W = cnt_width(SETUP_CYC, PULSE_CYC, HOLD_CYC);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DATA_W-1:0]  data_q;
  logic [N_LATCH-1:0] sel_q;
  logic [N_LATCH-1:0] strobe_q;
  logic               cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      data_q   <= '0;
      sel_q    <= '0;
      strobe_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          data_q  <= word_i;
          sel_q   <= sel_i;
          cnt_q   <= CNT_W'(SETUP_CYC - 1);
          state_q <= ST_SETUP;
        end
        ST_SETUP: if (cnt_zero) begin
          strobe_q <= sel_q;
          cnt_q    <= CNT_W'(PULSE_CYC - 1);
          state_q  <= ST_STROBE;
        end else cnt_q <= cnt_q - 1'b1;
        ST_STROBE: if (cnt_zero) begin
          strobe_q <= '0;
          cnt_q    <= CNT_W'(HOLD_CYC - 1);
          state_q  <= ST_HOLD;
        end else cnt_q <= cnt_q - 1'b1;
        ST_HOLD: if (cnt_zero) state_q <= ST_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o   = data_q;
  assign strobe_o = strobe_q;
  assign idle_o   = (state_q == ST_IDLE);

  // R5
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_q));
  // R6
  data_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(data_q));
  // R4
  setup_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && start_i) |=> (strobe_q == '0));
  // R6
  hold_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|strobe_q) |-> (state_q == ST_HOLD));
endmodule

// File: rtl/latch_expander.sv
module latch_expander #(
  parameter  int N_LATCH   = 2,
  parameter  int DATA_W    = 8,
  parameter  int SETUP_CYC = 2,
  parameter  int PULSE_CYC = 2,
  parameter  int HOLD_CYC  = 1,
  localparam int TOTAL     = N_LATCH * DATA_W,
  localparam int IDX_W     = $clog2(TOTAL) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [IDX_W-1:0]   req_idx_i,
  input  logic               req_val_i,
  output logic [DATA_W-1:0]  data_o,
  output logic [N_LATCH-1:0] strobe_o,
  output logic [TOTAL-1:0]   line_is_out_o
);
  logic [N_LATCH-1:0][DATA_W-1:0] hit;
  logic [N_LATCH-1:0]             sel;
  logic [DATA_W-1:0]              word;
  logic                           in_range;
  logic                           accept;
  logic                           idle;

  assign accept        = req_valid_i && req_ready_o;
  assign req_ready_o   = idle;
  assign line_is_out_o = '1;

  lx_index_decode #(.N_LATCH(N_LATCH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .idx_i (req_idx_i),
    .hit_o (hit)
  );

  lx_shadow_bank #(.N_LATCH(N_LATCH), .DATA_W(DATA_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (accept),
    .val_i      (req_val_i),
    .hit_i      (hit),
    .sel_o      (sel),
    .word_o     (word),
    .in_range_o (in_range)
  );

  lx_strobe_seq #(
    .N_LATCH(N_LATCH), .DATA_W(DATA_W),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept && in_range),
    .sel_i    (sel),
    .word_i   (word),
    .data_o   (data_o),
    .strobe_o (strobe_o),
    .idle_o   (idle)
  );

  // R7
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_range) |=> !req_ready_o);
  // R8
  oor_pins_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !in_range) |=> (req_ready_o && strobe_o == '0 && $stable(data_o)));
endmodule

// File: tb/latch_expander_bench.sv
`timescale 1ns/1ps
module latch_expander_bench;
  localparam int N_LATCH = 2;
  localparam int DATA_W  = 8;
  localparam int S_CYC   = 2;
  localparam int P_CYC   = 2;
  localparam int H_CYC   = 1;
  localparam int TOTAL   = N_LATCH * DATA_W;
  localparam int IDX_W   = $clog2(TOTAL) + 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [IDX_W-1:0]   req_idx = '0;
  logic               req_val = 1'b0;
  logic [DATA_W-1:0]  data;
  logic [N_LATCH-1:0] strobe;
  logic [TOTAL-1:0]   line_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N_LATCH-1:0][DATA_W-1:0] model = '0;
  logic [DATA_W-1:0] last_word = '0;

  always #10 clk = ~clk;

  latch_expander #(
    .N_LATCH(N_LATCH), .DATA_W(DATA_W),
    .SETUP_CYC(S_CYC), .PULSE_CYC(P_CYC), .HOLD_CYC(H_CYC)
  ) u_latch_expander (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_idx_i(req_idx), .req_val_i(req_val),
    .data_o(data), .strobe_o(strobe), .line_is_out_o(line_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // returns just after the posedge where the request was taken
  task automatic wait_accept();
    for (int g = 0; g < 100; g++) begin
      bit rdy;
      rdy = req_ready;
      @(posedge clk);
      if (rdy) return;
      @(negedge clk);
    end
    chk(1'b0, "R7 accept timeout", 0, 1);
  endtask

  // watch one full sequence; starts just after the accepting edge
  task automatic observe(input int lat, input logic [DATA_W-1:0] exp_w, input string tag);
    int s_n = 0, p_n = 0, h_n = 0;
    logic [N_LATCH-1:0] exp_sel;
    exp_sel = '0;
    exp_sel[lat] = 1'b1;
    @(negedge clk);
    while (strobe == '0 && s_n < 50) begin
      chk(data == exp_w, {"R3 word ", tag}, data, exp_w);
      chk(!req_ready, {"R7 busy in setup ", tag}, req_ready, 0);
      s_n++;
      @(negedge clk);
    end
    while (strobe != '0 && p_n < 50) begin
      chk(strobe == exp_sel, {"R5 strobe line ", tag}, strobe, exp_sel);
      chk(data == exp_w, {"R6 data in pulse ", tag}, data, exp_w);
      p_n++;
      @(negedge clk);
    end
    while (!req_ready && h_n < 50) begin
      chk(strobe == '0, {"R5 strobe low in hold ", tag}, strobe, 0);
      chk(data == exp_w, {"R6 data in hold ", tag}, data, exp_w);
      h_n++;
      @(negedge clk);
    end
    chk(s_n == S_CYC, {"R4 setup cycles ", tag}, s_n, S_CYC);
    chk(p_n == P_CYC, {"R5 pulse cycles ", tag}, p_n, P_CYC);
    chk(h_n == H_CYC, {"R6 hold cycles ", tag}, h_n, H_CYC);
    last_word = exp_w;
  endtask

  task automatic do_req(input int idx, input bit v, input string tag);
    int lat, bt;
    lat = idx / DATA_W;
    bt  = idx % DATA_W;
    @(negedge clk);
    req_idx = IDX_W'(idx);
    req_val = v;
    req_valid = 1'b1;
    wait_accept();
    #2 req_valid = 1'b0;
    model[lat][bt] = v;
    observe(lat, model[lat], tag);
  endtask

  task automatic t_reset();
    chk(data == '0, "R1 data low", data, 0);
    chk(strobe == '0, "R1 strobes low", strobe, 0);
    chk(req_ready == 1'b1, "R1 ready high", req_ready, 1);
    chk(line_out == '1, "R9 direction", line_out, {TOTAL{1'b1}});
  endtask

  task automatic t_mapping();
    do_req(3, 1'b1, "R2 idx3");
    do_req(13, 1'b1, "R2 idx13");
    chk(last_word == 8'h20, "R2 latch1 bit5", last_word, 8'h20);
  endtask

  task automatic t_rmw();
    do_req(0, 1'b1, "R3 set0");
    chk(last_word == 8'h09, "R3 keep bit3", last_word, 8'h09);
    do_req(3, 1'b0, "R3 clr3");
    chk(last_word == 8'h01, "R3 clear only bit3", last_word, 8'h01);
    do_req(15, 1'b1, "R10 latch1");
    chk(last_word == 8'hA0, "R10 latch1 word", last_word, 8'hA0);
    do_req(1, 1'b1, "R10 latch0 intact");
    chk(last_word == 8'h03, "R10 latch0 word", last_word, 8'h03);
  endtask

  task automatic t_out_of_range(input int idx);
    logic [DATA_W-1:0] held;
    held = data;
    @(negedge clk);
    req_idx = IDX_W'(idx);
    req_val = 1'b1;
    req_valid = 1'b1;
    wait_accept();
    #2 req_valid = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready stays high", req_ready, 1);
      chk(strobe == '0, "R8 no strobe", strobe, 0);
      chk(data == held, "R8 data unchanged", data, held);
    end
  endtask

  task automatic t_oor_shadows();
    t_out_of_range(TOTAL);
    t_out_of_range((1 << IDX_W) - 1);
    do_req(8, 1'b0, "R8 latch1 readback");
    chk(last_word == 8'hA0, "R8 latch1 shadow kept", last_word, 8'hA0);
    do_req(2, 1'b0, "R8 latch0 readback");
    chk(last_word == 8'h03, "R8 latch0 shadow kept", last_word, 8'h03);
  endtask

  task automatic t_serialize();
    @(negedge clk);
    req_idx = IDX_W'(7);
    req_val = 1'b1;
    req_valid = 1'b1;
    wait_accept();
    #2 req_idx = IDX_W'(9);
    model[0][7] = 1'b1;
    observe(0, model[0], "R7 first");
    chk(last_word == 8'h83, "R7 first word", last_word, 8'h83);
    wait_accept();
    #2 req_valid = 1'b0;
    model[1][1] = 1'b1;
    observe(1, model[1], "R7 second");
    chk(last_word == 8'hA2, "R7 second word", last_word, 8'hA2);
    chk(line_out == '1, "R9 direction after traffic", line_out, {TOTAL{1'b1}});
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_rmw();
    t_oor_shadows();
    t_serialize();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule